// File: doc/BRIEF.md
# Serial Configuration Register File

This block is the write-only configuration port of a sensor front end. A host shifts 16-bit frames in on a chip-select, serial-clock and serial-data trio. Each frame carries a register address and ten bits of data; the block decodes nine registers that set gain, user DAC codes, offset correction values, the black-level target, averaging setup and test options. It then presents every stored field on parallel outputs in the system clock domain.

The serial side runs on the serial clock only and is held in its idle state whenever chip select is high, so a frame that is cut short leaves no trace. A complete frame is handed across to the system clock through a toggle that is synchronized by two flops. A small state machine on the system side then commits the write. Two control bits act as one-shot commands: one returns every register to its default, the other issues a clear to the black-level averager. A hardware reset input and a standby pin complete the block.

Serial side states: `S_IDLE` (no bit taken yet in this frame), `S_SHIFT` (bits 2 to 16 arriving) and `S_DONE` (frame committed, further bits ignored). The transitions are: `S_IDLE` to `S_SHIFT` on the first clock, `S_SHIFT` to `S_DONE` on the sixteenth clock, and any state to `S_IDLE` when chip select rises. System side states: `R_WAIT` (no write pending) and `R_COMMIT` (apply the latched word). `R_WAIT` moves to `R_COMMIT` when the synchronized toggle changes, and `R_COMMIT` always returns to `R_WAIT` on the next clock.

Top module: `serial_cfg_regs`

## Requirements
- R1: After hardware reset every field is zero except the black target (0x040), the averaging setup (0x003) and the test setup (0x180), and both strobes are low.
- R2: Frames are sampled on rising serial-clock edges while chip select is low, most significant bit first. Bits 15 and 14 are ignored, bits 13 to 10 are the address and bits 9 to 0 are the data. Addresses 0 to 8 select control, gain, user DAC 1, user DAC 2, coarse offset, fine offset, black target, averaging setup and test. The register takes the value a few system clocks after the sixteenth bit and does not change at any other time.
- R3: Data bits with no field are dropped: gain keeps data bits 8..0, each user DAC keeps bits 7..0, and each offset keeps bit 8 as its negative-sign flag and bits 7..0 as its magnitude.
- R4: A frame addressed to 9 through 15 changes no output.
- R5: If chip select rises before the sixteenth bit, the frame is discarded, and the next frame is decoded from its own first bit.
- R6: Serial clocks after the sixteenth bit, while chip select stays low, have no effect.
- R7: A control write with data bit 0 set returns every register to its R1 default and raises the system-reset strobe for exactly one system clock.
- R8: A control write with data bit 1 set (bit 0 clear) raises the averager-clear strobe for exactly one system clock and also stores control bits 9..5 as usual.
- R9: Control data bits 9, 8, 7, 6 and 5 drive the standby request, the user DAC 1 power-down, the user DAC 2 power-down, the coarse bypass and the fine bypass. The standby output is high when control bit 9 is set or the standby pin is low. Writes still take effect while in standby.
- R10: Asserting the hardware reset at any time returns all fields to their R1 defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| ser_cs_n | input | 1 | Serial chip select, active low |
| ser_clk | input | 1 | Serial clock, data sampled on rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| stby_n | input | 1 | Standby pin, active low |
| standby | output | 1 | Combined standby (control bit 9 or pin) |
| udac1_off | output | 1 | User DAC 1 power-down |
| udac2_off | output | 1 | User DAC 2 power-down |
| coarse_bypass | output | 1 | Coarse offset manual mode |
| fine_bypass | output | 1 | Fine offset manual mode |
| gain | output | 9 | Gain code |
| udac1_code | output | 8 | User DAC 1 code |
| udac2_code | output | 8 | User DAC 2 code |
| coarse_neg | output | 1 | Coarse offset negative sign |
| coarse_mag | output | 8 | Coarse offset magnitude |
| fine_neg | output | 1 | Fine offset negative sign |
| fine_mag | output | 8 | Fine offset magnitude |
| black_target | output | 10 | Black-level target code |
| avg_setup | output | 10 | Averaging setup word |
| test_setup | output | 10 | Test setup word |
| sys_reset_pulse | output | 1 | One-clock strobe from control bit 0 |
| avg_clear_pulse | output | 1 | One-clock strobe from control bit 1 |

## Verification
The hardest case to reach from the ports is a frame that breaks framing: one that stops partway, or one that keeps clocking after its sixteenth bit. Either could leave a stale bit count that shifts every later frame out of alignment. The stimulus drives a ten-bit partial frame and then a full frame, and later a frame with four surplus clocks. After each one it compares the whole output image against a model, so any misalignment shows up as wrong data in the next register written. The one-shot strobes are measured by counting both their rising edges and their high cycles.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 10;
    localparam int NUM_REGS = 9;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_GAIN   = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_UDAC1  = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_UDAC2  = 4'd3;
    localparam logic [ADDR_W-1:0] ADDR_COARSE = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_FINE   = 4'd5;
    localparam logic [ADDR_W-1:0] ADDR_BLACK  = 4'd6;
    localparam logic [ADDR_W-1:0] ADDR_AVG    = 4'd7;
    localparam logic [ADDR_W-1:0] ADDR_TEST   = 4'd8;

    localparam logic [DATA_W-1:0] BLACK_DEF = 10'h040;
    localparam logic [DATA_W-1:0] AVG_DEF   = 10'h003;
    localparam logic [DATA_W-1:0] TEST_DEF  = 10'h180;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cfg_word_t;

    typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_DONE} ser_state_e;
    typedef enum logic {R_WAIT, R_COMMIT} reg_state_e;
endpackage

// File: rtl/cfg_shift.sv
`timescale 1ns/1ps
module cfg_shift
    import cfg_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic      rst_n,
    input  logic      ser_cs_n,
    input  logic      ser_clk,
    input  logic      ser_din,
    output cfg_word_t word_q,
    output logic      toggle_q
);
    localparam int CNT_W = $clog2(FW);
    localparam int SH_W  = ADDR_W + DATA_W - 1;

    logic             frame_arst_n;
    ser_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SH_W-1:0]  shift_q;
    logic             last_bit;

    // A frame lives only while chip select is low.
    assign frame_arst_n = rst_n & ~ser_cs_n;

    always_ff @(posedge ser_clk or negedge frame_arst_n) begin
        if (!frame_arst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shift_q <= {shift_q[SH_W-2:0], ser_din};
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        last_bit = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                state_d = S_SHIFT;
                cnt_d   = CNT_W'(1);
            end
            S_SHIFT: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == CNT_W'(FW - 1)) begin
                    state_d  = S_DONE;
                    last_bit = 1'b1;
                end
            end
            S_DONE: begin
                state_d = S_DONE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Commit register survives chip select; only hardware reset clears it.
    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            toggle_q <= 1'b0;
        end else if (last_bit) begin
            word_q   <= cfg_word_t'({shift_q, ser_din});
            toggle_q <= ~toggle_q;
        end
    end

    // R6: once the frame is committed, extra clocks produce no new commit.
    p_no_extra_commit_r6: assert property (@(posedge ser_clk) disable iff (!frame_arst_n)
        (state_q == S_DONE) |=> $stable(toggle_q));
endmodule

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_in,
    output logic pulse
);
    logic [STAGES:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-1:0], toggle_in};
    end

    assign pulse = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/cfg_regbank.sv
`timescale 1ns/1ps
module cfg_regbank
    import cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        commit_pulse,
    input  cfg_word_t   word_in,
    output logic [4:0]  ctrl_q,
    output logic [8:0]  gain_q,
    output logic [7:0]  udac1_q,
    output logic [7:0]  udac2_q,
    output logic [8:0]  coarse_q,
    output logic [8:0]  fine_q,
    output logic [9:0]  black_q,
    output logic [9:0]  avg_q,
    output logic [9:0]  test_q,
    output logic        sys_rst_stb,
    output logic        avg_clr_stb
);
    reg_state_e state_q, state_d;
    cfg_word_t  word_q;
    logic       is_commit;
    logic       sw_reset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_WAIT;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (commit_pulse) word_q <= word_in;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_WAIT:   if (commit_pulse) state_d = R_COMMIT;
            R_COMMIT: state_d = R_WAIT;
            default:  state_d = R_WAIT;
        endcase
    end

    assign is_commit = (state_q == R_COMMIT);
    assign sw_reset  = is_commit && (word_q.addr == ADDR_CTRL) && word_q.data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            gain_q   <= '0;
            udac1_q  <= '0;
            udac2_q  <= '0;
            coarse_q <= '0;
            fine_q   <= '0;
            black_q  <= BLACK_DEF;
            avg_q    <= AVG_DEF;
            test_q   <= TEST_DEF;
        end else if (sw_reset) begin
            ctrl_q   <= '0;
            gain_q   <= '0;
            udac1_q  <= '0;
            udac2_q  <= '0;
            coarse_q <= '0;
            fine_q   <= '0;
            black_q  <= BLACK_DEF;
            avg_q    <= AVG_DEF;
            test_q   <= TEST_DEF;
        end else if (is_commit) begin
            case (word_q.addr)
                ADDR_CTRL:   ctrl_q   <= word_q.data[9:5];
                ADDR_GAIN:   gain_q   <= word_q.data[8:0];
                ADDR_UDAC1:  udac1_q  <= word_q.data[7:0];
                ADDR_UDAC2:  udac2_q  <= word_q.data[7:0];
                ADDR_COARSE: coarse_q <= word_q.data[8:0];
                ADDR_FINE:   fine_q   <= word_q.data[8:0];
                ADDR_BLACK:  black_q  <= word_q.data;
                ADDR_AVG:    avg_q    <= word_q.data;
                ADDR_TEST:   test_q   <= word_q.data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_rst_stb <= 1'b0;
            avg_clr_stb <= 1'b0;
        end else begin
            sys_rst_stb <= sw_reset;
            avg_clr_stb <= is_commit && (word_q.addr == ADDR_CTRL) && word_q.data[1];
        end
    end

    // R2: registers move only in the cycle after a commit.
    p_commit_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_WAIT) |=> $stable({ctrl_q, gain_q, udac1_q, udac2_q, coarse_q,
                                         fine_q, black_q, avg_q, test_q}));
    // R4: unmapped addresses leave everything alone.
    p_unmapped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_commit && word_q.addr > LAST_ADDR) |=> $stable({ctrl_q, gain_q, udac1_q,
            udac2_q, coarse_q, fine_q, black_q, avg_q, test_q}));
    // R7: strobe is one clock and coincides with default values.
    p_sysstb_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_stb |=> !sys_rst_stb);
    p_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_stb |-> (black_q == BLACK_DEF && avg_q == AVG_DEF &&
                         test_q == TEST_DEF && gain_q == '0 && ctrl_q == '0));
    // R8: averager clear is one clock wide.
    p_avgstb_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        avg_clr_stb |=> !avg_clr_stb);
endmodule

// File: rtl/serial_cfg_regs.sv
`timescale 1ns/1ps
module serial_cfg_regs
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_cs_n,
    input  logic       ser_clk,
    input  logic       ser_din,
    input  logic       stby_n,
    output logic       standby,
    output logic       udac1_off,
    output logic       udac2_off,
    output logic       coarse_bypass,
    output logic       fine_bypass,
    output logic [8:0] gain,
    output logic [7:0] udac1_code,
    output logic [7:0] udac2_code,
    output logic       coarse_neg,
    output logic [7:0] coarse_mag,
    output logic       fine_neg,
    output logic [7:0] fine_mag,
    output logic [9:0] black_target,
    output logic [9:0] avg_setup,
    output logic [9:0] test_setup,
    output logic       sys_reset_pulse,
    output logic       avg_clear_pulse
);
    cfg_word_t  ser_word;
    logic       ser_toggle;
    logic       commit_pulse;
    logic [4:0] ctrl_q;
    logic [8:0] coarse_q;
    logic [8:0] fine_q;

    cfg_shift #(.FW(FRAME_W)) u_shift (
        .rst_n    (rst_n),
        .ser_cs_n (ser_cs_n),
        .ser_clk  (ser_clk),
        .ser_din  (ser_din),
        .word_q   (ser_word),
        .toggle_q (ser_toggle)
    );

    cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .toggle_in (ser_toggle),
        .pulse     (commit_pulse)
    );

    cfg_regbank u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_pulse (commit_pulse),
        .word_in      (ser_word),
        .ctrl_q       (ctrl_q),
        .gain_q       (gain),
        .udac1_q      (udac1_code),
        .udac2_q      (udac2_code),
        .coarse_q     (coarse_q),
        .fine_q       (fine_q),
        .black_q      (black_target),
        .avg_q        (avg_setup),
        .test_q       (test_setup),
        .sys_rst_stb  (sys_reset_pulse),
        .avg_clr_stb  (avg_clear_pulse)
    );

    assign standby       = ctrl_q[4] | ~stby_n;
    assign udac1_off     = ctrl_q[3];
    assign udac2_off     = ctrl_q[2];
    assign coarse_bypass = ctrl_q[1];
    assign fine_bypass   = ctrl_q[0];
    assign coarse_neg    = coarse_q[8];
    assign coarse_mag    = coarse_q[7:0];
    assign fine_neg      = fine_q[8];
    assign fine_mag      = fine_q[7:0];
endmodule

// File: tb/test_serial_cfg_regs.sv
`timescale 1ns/1ps
module test_serial_cfg_regs;
    localparam int OBS_W = 78;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_cs_n = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_din = 1'b0;
    logic stby_n = 1'b1;
    logic standby, udac1_off, udac2_off, coarse_bypass, fine_bypass;
    logic [8:0] gain;
    logic [7:0] udac1_code, udac2_code, coarse_mag, fine_mag;
    logic coarse_neg, fine_neg;
    logic [9:0] black_target, avg_setup, test_setup;
    logic sys_reset_pulse, avg_clear_pulse;

    always #4 clk = ~clk;

    serial_cfg_regs i_serial_cfg_regs (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .stby_n(stby_n), .standby(standby),
        .udac1_off(udac1_off), .udac2_off(udac2_off),
        .coarse_bypass(coarse_bypass), .fine_bypass(fine_bypass),
        .gain(gain), .udac1_code(udac1_code), .udac2_code(udac2_code),
        .coarse_neg(coarse_neg), .coarse_mag(coarse_mag),
        .fine_neg(fine_neg), .fine_mag(fine_mag),
        .black_target(black_target), .avg_setup(avg_setup),
        .test_setup(test_setup), .sys_reset_pulse(sys_reset_pulse),
        .avg_clear_pulse(avg_clear_pulse)
    );

    typedef struct {
        string             req;
        logic [OBS_W-1:0]  exp;
    } item_t;

    item_t       exp_q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [9:0]  m [0:8];

    logic [OBS_W-1:0] obs;
    assign obs = {standby, udac1_off, udac2_off, coarse_bypass, fine_bypass, gain,
                  udac1_code, udac2_code, coarse_neg, coarse_mag, fine_neg, fine_mag,
                  black_target, avg_setup, test_setup};

    // Expected image built from the field map in the requirements.
    function automatic logic [OBS_W-1:0] model_image();
        return {m[0][9] | ~stby_n, m[0][8], m[0][7], m[0][6], m[0][5], m[1][8:0],
                m[2][7:0], m[3][7:0], m[4][8], m[4][7:0], m[5][8], m[5][7:0],
                m[6], m[7], m[8]};
    endfunction

    task automatic model_defaults();
        for (int i = 0; i < 9; i++) m[i] = 10'h000;
        m[6] = 10'h040;
        m[7] = 10'h003;
        m[8] = 10'h180;
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor.
    initial begin
        forever begin
            item_t it;
            wait (exp_q.size() != 0);
            @(negedge clk);
            it = exp_q.pop_front();
            checks++;
            if (obs !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.req, obs, it.exp);
            end
        end
    end

    // Strobe counters, sampled away from the active edge.
    int sys_hi = 0, sys_rise = 0, avg_hi = 0, avg_rise = 0;
    logic sys_prev = 1'b0, avg_prev = 1'b0;
    always @(negedge clk) begin
        if (sys_reset_pulse) sys_hi++;
        if (sys_reset_pulse && !sys_prev) sys_rise++;
        if (avg_clear_pulse) avg_hi++;
        if (avg_clear_pulse && !avg_prev) avg_rise++;
        sys_prev = sys_reset_pulse;
        avg_prev = avg_clear_pulse;
    end

    task automatic send_frame(input logic [15:0] f, input int nbits, input int extra);
        ser_cs_n = 1'b0;
        #10;
        for (int i = 0; i < nbits; i++) begin
            ser_din = f[15-i];
            #20 ser_clk = 1'b1;
            #20 ser_clk = 1'b0;
        end
        for (int i = 0; i < extra; i++) begin
            ser_din = 1'b1;
            #20 ser_clk = 1'b1;
            #20 ser_clk = 1'b0;
        end
        #10 ser_cs_n = 1'b1;
        #20;
    endtask

    task automatic expect_now(string req);
        item_t it;
        repeat (10) @(posedge clk);
        it.req = req;
        it.exp = model_image();
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
        #1;
    endtask

    task automatic wr(input logic [1:0] lead, input logic [3:0] a, input logic [9:0] d,
                      input int extra, string req);
        send_frame({lead, a, d}, 16, extra);
        if (a <= 4'd8) begin
            if (a == 4'd0 && d[0]) model_defaults();
            else m[a] = d;
        end
        expect_now(req);
    endtask

    initial begin
        model_defaults();
        #30 rst_n = 1'b1;
        expect_now("R1 reset defaults");
        check_int("R1 no strobe at reset", sys_hi + avg_hi, 0);

        // R2 / R3 field mapping and dropped bits
        wr(2'b11, 4'd1, 10'h2AB, 0, "R3 gain bit9 dropped");
        wr(2'b00, 4'd2, 10'h3FF, 0, "R3 udac1 upper bits dropped");
        wr(2'b01, 4'd3, 10'h155, 0, "R2 udac2 write");
        wr(2'b10, 4'd4, 10'h3C4, 0, "R3 coarse sign and magnitude");
        wr(2'b00, 4'd5, 10'h2A5, 0, "R3 fine sign and magnitude");
        wr(2'b11, 4'd6, 10'h2D3, 0, "R2 black target write");
        wr(2'b00, 4'd7, 10'h1F6, 0, "R2 averaging setup write");
        wr(2'b00, 4'd8, 10'h05A, 0, "R2 test setup write");

        // R9 control fields, standby, writes during standby
        wr(2'b00, 4'd0, 10'h3E0, 0, "R9 control fields set");
        wr(2'b00, 4'd1, 10'h011, 0, "R9 write accepted in standby");
        wr(2'b00, 4'd0, 10'h0A0, 0, "R9 control bit9 cleared");
        stby_n = 1'b0;
        expect_now("R9 standby pin low");
        stby_n = 1'b1;
        expect_now("R9 standby pin released");

        // R4 unmapped addresses
        wr(2'b00, 4'd9,  10'h3FF, 0, "R4 address 9 ignored");
        wr(2'b11, 4'd12, 10'h000, 0, "R4 address 12 ignored");
        wr(2'b00, 4'd15, 10'h2AA, 0, "R4 address 15 ignored");

        // R5 truncated frame, then realignment
        send_frame({2'b00, 4'd1, 10'h1FF}, 10, 0);
        expect_now("R5 short frame discarded");
        wr(2'b00, 4'd1, 10'h077, 0, "R5 next frame aligned");

        // R6 surplus clocks
        wr(2'b00, 4'd8, 10'h3C3, 4, "R6 extra clocks ignored");
        wr(2'b00, 4'd6, 10'h101, 0, "R6 following frame aligned");

        // R8 averager clear
        wr(2'b00, 4'd0, 10'h042, 0, "R8 averager clear keeps registers");
        check_int("R8 averager strobe count", avg_rise, 1);
        check_int("R8 averager strobe width", avg_hi, 1);
        check_int("R8 no system strobe", sys_hi, 0);

        // R7 software reset
        wr(2'b00, 4'd0, 10'h3E1, 0, "R7 software reset to defaults");
        check_int("R7 system strobe count", sys_rise, 1);
        check_int("R7 system strobe width", sys_hi, 1);

        // R10 hardware reset
        wr(2'b00, 4'd7, 10'h0AA, 0, "R10 setup before reset");
        wr(2'b00, 4'd0, 10'h200, 0, "R10 control before reset");
        @(negedge clk);
        rst_n = 1'b0;
        #30 rst_n = 1'b1;
        model_defaults();
        expect_now("R10 hardware reset defaults");
        wr(2'b00, 4'd5, 10'h1FE, 0, "R10 writes after reset");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule